// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces auto-refresh for an eight-bank DDR2 memory. A free-running interval timer counts controller clock cycles against a programmed period. One period is about 7.8 µs of clock cycles, for example 3120 cycles at 400 MHz. Each time the timer expires, one more refresh becomes owed. When the case-temperature flag reports the range between 85 °C and 95 °C, the timer runs at half the programmed period, which doubles the refresh rate. Each owed refresh covers all eight banks, so the controller needs only one command per owed refresh.

Owed refreshes are kept in a small saturating tally of up to eight. The controller may postpone refreshes for a while without losing them. The request output stays high while anything is owed, and each acknowledge retires one refresh. The urgent output reports that the tally is full. The controller must then refresh before any other traffic, because a further expiry would be lost. Issuing the command, closing banks and entering self-refresh belong to the controller.

Top module: `rfsh_scheduler`

## Requirements
- R1: While reset is high, the owed tally clears to zero and the timer restarts. After reset is released, the first expiry falls exactly `interval_i` cycles later, whatever the temperature flag is.
- R2: With `hot_i` low, expiries repeat every `interval_i` cycles. The first rising edge of `req_o` is observed `interval_i` clock edges after reset is released.
- R3: A period that starts with `hot_i` high lasts floor(`interval_i`/2) cycles. Any period that would work out to zero cycles lasts one cycle instead, for example `interval_i` of 0, or of 1 when hot.
- R4: The period length is chosen from `hot_i` and `interval_i` as sampled at the expiry edge that starts the period. A change between two expiries does not alter the running period.
- R5: An expiry without an acknowledge adds one to the owed tally. The tally saturates at 8, and expiries that arrive while it is full are lost.
- R6: An acknowledge without an expiry retires one owed refresh. An acknowledge while nothing is owed is ignored, and the tally does not wrap.
- R7: When an expiry and an acknowledge arrive in the same cycle while something is owed, the tally is unchanged. If nothing is owed, the expiry counts and the acknowledge is ignored.
- R8: `req_o` is high exactly when the owed tally is nonzero.
- R9: `urgent_o` is high exactly when the owed tally equals 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hot_i | input | 1 | High when case temperature is in the 85–95 °C range |
| interval_i | input | CNT_W (16) | Programmed refresh period in clock cycles |
| ack_i | input | 1 | One-cycle pulse per refresh the controller has issued |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed tally is full (8) |

## Verification
The timer expiry and the controller acknowledge can land on the same clock edge. The result then depends on whether anything is owed and whether the tally is full. The bench forces this coincidence on purpose by placing an acknowledge on the exact edge where the timer expires. It also sweeps short periods of 0 to 7 cycles with pseudo-random acknowledge and temperature patterns, so that coincidences occur at a tally of zero, in mid-range and at full. Each cycle the request and urgent outputs are compared with an arithmetic model of period and tally built from the requirements.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Action applied to the owed tally in one cycle
    typedef enum logic [1:0] {
        PA_HOLD = 2'd0,
        PA_INC  = 2'd1,
        PA_DEC  = 2'd2
    } pend_act_e;

    // Period length for the next interval: halved when hot, never below one
    function automatic logic [31:0] period_sel(input logic hot, input logic [31:0] iv);
        logic [31:0] p;
        p = hot ? (iv >> 1) : iv;
        if (p == 32'd0) p = 32'd1;
        return p;
    endfunction

    // Decide the tally update from expiry, acknowledge and tally state
    function automatic pend_act_e pick_act(input logic tick, input logic ack,
                                           input logic nonzero, input logic full);
        pend_act_e a;
        a = PA_HOLD;
        if (tick) begin
            if (!(ack && nonzero) && !full) a = PA_INC;
        end else if (ack && nonzero) begin
            a = PA_DEC;
        end
        return a;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hot_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             tick_o
);
    import rfsh_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    // Expiry on the last cycle of the latched period
    assign tick_o = (cnt_q == (lim_q - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(period_sel(1'b0, 32'(interval_i)));
        end else if (tick_o) begin
            cnt_q <= '0;
            lim_q <= CNT_W'(period_sel(hot_i, 32'(interval_i)));
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              ack_i,
    output logic [PEND_W-1:0] pend_o
);
    import rfsh_pkg::*;

    logic [PEND_W-1:0] pend_q;
    logic              nonzero;
    logic              full;
    pend_act_e         act;

    assign nonzero = (pend_q != '0);
    assign full    = (pend_q == PEND_W'(MAX_PEND));
    assign act     = pick_act(tick_i, ack_i, nonzero, full);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            unique case (act)
                PA_INC:  pend_q <= pend_q + PEND_W'(1);
                PA_DEC:  pend_q <= pend_q - PEND_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler #(
    parameter int CNT_W    = 16,
    parameter int MAX_PEND = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hot_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             urgent_o
);
    localparam int PEND_W = $clog2(MAX_PEND + 1);

    logic              tick;
    logic [PEND_W-1:0] pend_cnt;

    rfsh_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .hot_i      (hot_i),
        .interval_i (interval_i),
        .tick_o     (tick)
    );

    rfsh_pending_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ack_i  (ack_i),
        .pend_o (pend_cnt)
    );

    assign req_o    = (pend_cnt != '0);
    assign urgent_o = (pend_cnt == PEND_W'(MAX_PEND));

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              ack,
    input logic [PEND_W-1:0] pend
);
    // R1: tally is empty on the first edge after reset
    assert_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend == '0));

    // R5: expiry alone adds one below the ceiling
    assert_expiry_adds_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ack && pend < PEND_W'(MAX_PEND)) |=> (pend == $past(pend) + PEND_W'(1)));

    // R5: expiry alone at the ceiling is dropped
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !ack && pend == PEND_W'(MAX_PEND)) |=> (pend == PEND_W'(MAX_PEND)));

    // R6: acknowledge alone retires one
    assert_ack_retires_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && ack && pend != '0) |=> (pend == $past(pend) - PEND_W'(1)));

    // R6: acknowledge with nothing owed is ignored
    assert_ack_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick && ack && pend == '0) |=> (pend == '0));

    // R7: coincident expiry and acknowledge leave a nonzero tally alone
    assert_coincide_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && ack && pend != '0) |=> $stable(pend));

endmodule

bind rfsh_scheduler rfsh_sched_chk #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .ack  (ack_i),
    .pend (pend_cnt)
);

// File: tb/rfsh_scheduler_test.sv
module rfsh_scheduler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hot = 1'b0;
    logic        ack = 1'b0;
    logic [15:0] iv  = 16'd10;
    logic        req;
    logic        urg;

    always #5 clk = ~clk;

    rfsh_scheduler #(.CNT_W(16), .MAX_PEND(8)) uut (
        .clk(clk), .rst(rst), .hot_i(hot), .interval_i(iv),
        .ack_i(ack), .req_o(req), .urgent_o(urg)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int m_cnt, m_lim, m_pend;
    bit m_tick;
    logic [15:0] lf = 16'hACE1;

    function automatic int eff(bit h, int v);
        int x;
        x = h ? v / 2 : v;
        return (x == 0) ? 1 : x;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model, compare after the edge
    task automatic step(bit r, bit h, bit a);
        @(negedge clk);
        rst = r; hot = h; ack = a;
        @(posedge clk);
        #1;
        if (r) begin
            m_cnt = 0; m_lim = eff(1'b0, int'(iv)); m_pend = 0; m_tick = 0;
        end else begin
            m_tick = (m_cnt == m_lim - 1);
            if (m_tick) begin m_cnt = 0; m_lim = eff(h, int'(iv)); end
            else m_cnt++;
            if (m_tick && !(a && m_pend > 0)) begin
                if (m_pend < 8) m_pend++;
            end else if (!m_tick && a && m_pend > 0) begin
                m_pend--;
            end
        end
        chk(req == (m_pend != 0), "R8 req", int'(req), int'(m_pend != 0));
        chk(urg == (m_pend == 8), "R9 urgent", int'(urg), int'(m_pend == 8));
    endtask

    // Cycles from a request rise to the next, acking once right after the rise
    task automatic gap(bit h, output int n);
        n = 1;
        step(1'b0, h, 1'b1);
        while (!req && n < 200) begin
            step(1'b0, h, 1'b0);
            n++;
        end
    endtask

    int g;

    initial begin
        // R1 and R2: reset, then first expiry after exactly 10 cycles
        iv = 16'd10;
        repeat (3) step(1'b1, 1'b0, 1'b0);
        chk(!req && !urg, "R1 reset outputs", int'({req, urg}), 0);
        repeat (9) step(1'b0, 1'b0, 1'b0);
        chk(!req, "R2 no request before period", int'(req), 0);
        step(1'b0, 1'b0, 1'b0);
        chk(req, "R2 request at period", int'(req), 1);

        // R9: urgent only at the eighth expiry (edge 80)
        repeat (69) step(1'b0, 1'b0, 1'b0);
        chk(!urg, "R9 not urgent at seven", int'(urg), 0);
        step(1'b0, 1'b0, 1'b0);
        chk(urg, "R9 urgent at eight", int'(urg), 1);

        // R5: three more expiries are lost (edges 90,100,110)
        repeat (30) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk(req && !urg, "R9 urgent drops after one ack", int'(urg), 0);
        repeat (6) step(1'b0, 1'b0, 1'b1);
        chk(req, "R5 one still owed after seven acks", int'(req), 1);
        step(1'b0, 1'b0, 1'b1);
        chk(!req, "R5 saturated tally empty after eight acks", int'(req), 0);

        // R6: ack with nothing owed is ignored, no wrap
        step(1'b0, 1'b0, 1'b1);
        chk(!req, "R6 ack at zero ignored", int'(req), 0);
        step(1'b0, 1'b0, 1'b0);
        chk(req, "R6 next expiry gives exactly one", int'(req), 1);

        // R7: ack on the expiry edge (edge 130) keeps one owed
        repeat (9) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk(req, "R7 coincident keeps tally", int'(req), 1);
        step(1'b0, 1'b0, 1'b1);
        chk(!req, "R7 single ack then empties", int'(req), 0);

        // R1, R3, R4: hot reset uses full period, then halved, change at boundary
        repeat (2) step(1'b1, 1'b1, 1'b0);
        g = 0;
        while (!req && g < 200) begin step(1'b0, 1'b1, 1'b0); g++; end
        chk(g == 10, "R1 full period after reset while hot", g, 10);
        gap(1'b1, g);
        chk(g == 5, "R3 hot period halved", g, 5);
        gap(1'b0, g);
        chk(g == 5, "R4 cooling waits for boundary", g, 5);
        gap(1'b0, g);
        chk(g == 10, "R4 cool period after boundary", g, 10);

        // R3: odd interval and minimum of one
        iv = 16'd7;
        repeat (2) step(1'b1, 1'b1, 1'b0);
        g = 0;
        while (!req && g < 200) begin step(1'b0, 1'b1, 1'b0); g++; end
        gap(1'b1, g);
        chk(g == 3, "R3 odd interval halves down", g, 3);
        iv = 16'd1;
        repeat (2) step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        chk(req, "R3 one-cycle period expires at once", int'(req), 1);
        step(1'b0, 1'b1, 1'b1);
        chk(req, "R3 R7 every-cycle expiry with ack holds", int'(req), 1);

        // Sweep of short periods with varied ack and temperature patterns
        for (int v = 0; v < 8; v++) begin
            for (int mode = 0; mode < 2; mode++) begin
                iv = 16'(v);
                repeat (2) step(1'b1, 1'b0, 1'b0);
                for (int c = 0; c < 120; c++) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    step(1'b0, (c % 17 < 8) ^ mode[0],
                         mode[0] ? (lf[0] & lf[1] & lf[2]) : lf[0]);
                end
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule